// File: doc/BRIEF.md
# Speculative One-Tap Decision-Feedback Slicer

This block turns a stream of digitized two-level line samples into recovered bits. The samples are signed fixed-point values, one per clock, with nominal symbol levels of +1.0 and -1.0. Each sample also carries interference of +a or -a from the bit that came before it. The block cancels this first post-cursor term. It does not subtract an estimate of the interference in the feedback loop. Instead, it slices every sample against two shifted thresholds at the same time, and the decision already held in a register picks one of the two results. The only logic in the bit-to-bit loop is therefore a 2:1 select. Interference from later symbols is not removed.

The coefficient a is held in a signed register that uses the sample's format. It can be written only in cycles that carry no sample. After reset it is zero, so the block then acts as a plain slicer with its threshold at zero. Decisions and their valid flag appear one clock after the sample. Cycles without a sample leave the feedback state as it was.

Top module: `spec_dfe_slicer`

## Requirements
- R1: While reset is high, the block clears the bit output, the output valid flag and the coefficient to zero at the next clock edge.
- R2: The output valid flag equals the input valid flag of the previous cycle.
- R3: When the held decision is 1 and a valid sample arrives, the next decision is 1 exactly when the sample is strictly greater than +a.
- R4: When the held decision is 0 and a valid sample arrives, the next decision is 1 exactly when the sample is strictly greater than -a.
- R5: A sample exactly equal to the selected threshold decides 0.
- R6: In a cycle whose input valid flag is low, the bit output and the held decision keep their value.
- R7: A coefficient write in a cycle with the input valid flag low takes effect for the next sample. A write in a cycle with the valid flag high is ignored.
- R8: With the reset-default coefficient of zero, the decision is 1 exactly for samples greater than zero, whatever the previous decision was.
- R9: The thresholds are formed one bit wider than the sample, so a coefficient at either end of the signed range (most negative or most positive) produces the exact thresholds -a and +a without wrapping.
- R10: When the noise added to the one-tap channel is bounded below 1.0 in magnitude, the block makes no bit errors. With a > 1.0, a zero-threshold slicer on the same data does make errors.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_i | input | W | Signed fixed-point line sample |
| smp_vld_i | input | 1 | Sample valid strobe |
| coef_wr_i | input | 1 | Coefficient write strobe (honoured only when smp_vld_i is low) |
| coef_i | input | W | Signed post-cursor coefficient to load |
| bit_o | output | 1 | Recovered bit; also the held previous decision |
| bit_vld_o | output | 1 | Valid flag for bit_o |

## Verification
The held decision steers every later choice of threshold, so a decision register that is wrong in a single cycle shows up at bit_o on the next valid sample: that sample is sliced against the wrong threshold. Samples are placed between +a and -a so that the two branches disagree and such a fault becomes visible at once. A coefficient that was corrupted, or written when it should not have been, shows up in the first sample near a threshold. The bench sets up exactly these cases, with ties at both thresholds, coefficients at both ends of the signed range, and gaps in the sample stream. Long channel runs then confirm that no bits are in error.

// File: rtl/dfe_pkg.sv
package dfe_pkg;

    // One decision bit, named for readability in the feedback path.
    typedef enum logic {
        DEC_ZERO = 1'b0,
        DEC_ONE  = 1'b1
    } dec_e;

    // Speculative comparison results for one sample.
    typedef struct packed {
        logic gt_hi;   // sample > +coef (valid branch when previous decision was 1)
        logic gt_lo;   // sample > -coef (valid branch when previous decision was 0)
    } spec_pair_t;

    // Number of speculative branches for a one-tap, two-level loop.
    localparam int unsigned N_BRANCH = 2;

    // The only logic inside the bit-to-bit loop: a 2:1 select.
    function automatic dec_e pick_branch(input spec_pair_t pair, input dec_e prev);
        return (prev == DEC_ONE) ? dec_e'(pair.gt_hi) : dec_e'(pair.gt_lo);
    endfunction

endpackage

// File: rtl/dfe_coef_reg.sv
module dfe_coef_reg #(
    parameter int W = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic                busy,
    input  logic signed [W-1:0] din,
    output logic signed [W-1:0] q
);

    logic take;

    // Writes are accepted only while no sample is in flight.
    assign take = wr_en && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (take) begin
            q <= din;
        end
    end

endmodule

// File: rtl/dfe_thresh_cmp.sv
module dfe_thresh_cmp
    import dfe_pkg::*;
#(
    parameter int W = 12
) (
    input  logic signed [W-1:0] smp,
    input  logic signed [W-1:0] coef,
    output spec_pair_t          pair
);

    localparam int WX = W + 1;

    logic signed [WX-1:0] smp_x;
    logic signed [WX-1:0] coef_x;
    logic signed [WX-1:0] thr   [N_BRANCH];
    logic [N_BRANCH-1:0]  gt;

    // One extra bit keeps -coef exact for the most negative coefficient.
    assign smp_x  = WX'(smp);
    assign coef_x = WX'(coef);

    for (genvar g = 0; g < N_BRANCH; g++) begin : g_branch
        if (g == 0) begin : g_lo
            assign thr[g] = -coef_x;
        end else begin : g_hi
            assign thr[g] = coef_x;
        end
        // Strict compare: a tie decides 0.
        assign gt[g] = (smp_x > thr[g]);
    end

    assign pair.gt_lo = gt[0];
    assign pair.gt_hi = gt[1];

endmodule

// File: rtl/dfe_decision_reg.sv
module dfe_decision_reg
    import dfe_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       vld_in,
    input  spec_pair_t pair,
    output dec_e       dec_q,
    output logic       vld_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_q <= DEC_ZERO;
            vld_q <= 1'b0;
        end else begin
            vld_q <= vld_in;
            if (vld_in) begin
                dec_q <= pick_branch(pair, dec_q);
            end
        end
    end

endmodule

// File: rtl/spec_dfe_slicer.sv
module spec_dfe_slicer
    import dfe_pkg::*;
#(
    parameter int W = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic signed [W-1:0] smp_i,
    input  logic                smp_vld_i,
    input  logic                coef_wr_i,
    input  logic signed [W-1:0] coef_i,
    output logic                bit_o,
    output logic                bit_vld_o
);

    logic signed [W-1:0] coef_q;
    spec_pair_t          pair;
    dec_e                dec_q;

    dfe_coef_reg #(.W(W)) u_coef (
        .clk   (clk),
        .rst   (rst),
        .wr_en (coef_wr_i),
        .busy  (smp_vld_i),
        .din   (coef_i),
        .q     (coef_q)
    );

    dfe_thresh_cmp #(.W(W)) u_cmp (
        .smp  (smp_i),
        .coef (coef_q),
        .pair (pair)
    );

    dfe_decision_reg u_dec (
        .clk    (clk),
        .rst    (rst),
        .vld_in (smp_vld_i),
        .pair   (pair),
        .dec_q  (dec_q),
        .vld_q  (bit_vld_o)
    );

    assign bit_o = dec_q;

endmodule

// File: rtl/spec_dfe_slicer_chk.sv
module spec_dfe_slicer_chk #(
    parameter int W = 12
) (
    input logic                clk,
    input logic                rst,
    input logic signed [W-1:0] smp_i,
    input logic                smp_vld_i,
    input logic                bit_o,
    input logic                bit_vld_o,
    input logic signed [W-1:0] coef_q
);

    logic signed [W:0] smp_x;
    logic signed [W:0] pos_x;
    logic signed [W:0] neg_x;

    assign smp_x = (W+1)'(smp_i);
    assign pos_x = (W+1)'(coef_q);
    assign neg_x = -pos_x;

    // R1
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (!bit_o && !bit_vld_o && coef_q == '0));

    // R2
    a_r2_valid_follow: assert property (@(posedge clk) disable iff (rst)
        smp_vld_i |=> bit_vld_o);
    a_r2_invalid_follow: assert property (@(posedge clk) disable iff (rst)
        !smp_vld_i |=> !bit_vld_o);

    // R3, R5
    a_r3_high_branch: assert property (@(posedge clk) disable iff (rst)
        (smp_vld_i && bit_o) |=> (bit_o == ($past(smp_x) > $past(pos_x))));

    // R4, R5
    a_r4_low_branch: assert property (@(posedge clk) disable iff (rst)
        (smp_vld_i && !bit_o) |=> (bit_o == ($past(smp_x) > $past(neg_x))));

    // R6
    a_r6_hold_in_gap: assert property (@(posedge clk) disable iff (rst)
        !smp_vld_i |=> $stable(bit_o));

    // R7
    a_r7_coef_locked: assert property (@(posedge clk) disable iff (rst)
        smp_vld_i |=> $stable(coef_q));

endmodule

bind spec_dfe_slicer spec_dfe_slicer_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .smp_i     (smp_i),
    .smp_vld_i (smp_vld_i),
    .bit_o     (bit_o),
    .bit_vld_o (bit_vld_o),
    .coef_q    (coef_q)
);

// File: tb/test_spec_dfe_slicer.sv
module test_spec_dfe_slicer;

    localparam int W    = 12;
    localparam int FRAC = 9;
    localparam int ONE  = 1 << FRAC;   // 1.0 in sample units
    localparam int NTBL = 12;
    localparam int NBIT = 2000;

    // Entry: {valid, expected bit, sample}; walked with coefficient 256 from decision 0.
    localparam logic [W+1:0] TBL [NTBL] = '{
        {1'b1, 1'b1,  12'sd300},   // R4: prev 0, 300 > -256
        {1'b1, 1'b0,  12'sd200},   // R3: prev 1, 200 <= 256
        {1'b1, 1'b0, -12'sd256},   // R5: tie at -256
        {1'b1, 1'b1, -12'sd255},   // R4
        {1'b1, 1'b0,  12'sd256},   // R5: tie at +256
        {1'b0, 1'b0,  12'sd500},   // R6: gap, hold 0
        {1'b1, 1'b1, -12'sd100},   // R4
        {1'b0, 1'b1, -12'sd100},   // R6: gap, hold 1
        {1'b1, 1'b0,  12'sd100},   // R3
        {1'b1, 1'b1,  12'sd257},   // R4
        {1'b1, 1'b1,  12'sd257},   // R3
        {1'b1, 1'b0, -12'sd2048}   // R3
    };

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic signed [W-1:0] smp_i = '0;
    logic                smp_vld_i = 1'b0;
    logic                coef_wr_i = 1'b0;
    logic signed [W-1:0] coef_i = '0;
    logic                bit_o;
    logic                bit_vld_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    spec_dfe_slicer #(.W(W)) i_spec_dfe_slicer (
        .clk       (clk),
        .rst       (rst),
        .smp_i     (smp_i),
        .smp_vld_i (smp_vld_i),
        .coef_wr_i (coef_wr_i),
        .coef_i    (coef_i),
        .bit_o     (bit_o),
        .bit_vld_o (bit_vld_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; smp_vld_i = 1'b0; coef_wr_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic load_coef(input int v);
        @(negedge clk);
        smp_vld_i = 1'b0; coef_wr_i = 1'b1; coef_i = W'(v);
        @(negedge clk);
        coef_wr_i = 1'b0;
    endtask

    // Drive one valid sample at a falling edge, check at the next one.
    task automatic slice(input int s, input int exp, input string req);
        smp_i = W'(s); smp_vld_i = 1'b1;
        @(negedge clk);
        smp_vld_i = 1'b0;
        check(req, int'(bit_o), exp);
    endtask

    task automatic run_channel(input int alpha, input int noise,
                               output int dfe_err, output int zs_err);
        int prev = 0;
        dfe_err = 0; zs_err = 0;
        do_reset();
        load_coef(alpha);
        for (int k = 0; k < NBIT; k++) begin
            int b  = int'($urandom_range(1));
            int nz = int'($urandom_range(2 * noise)) - noise;
            int rx = (b != 0 ? ONE : -ONE) + (prev != 0 ? alpha : -alpha) + nz;
            smp_i = W'(rx); smp_vld_i = 1'b1;
            if ((rx > 0 ? 1 : 0) != b) zs_err++;
            @(negedge clk);
            if (int'(bit_o) != b) dfe_err++;
            prev = b;
        end
        smp_vld_i = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int de;
        int ze;

        // R1: state while reset is held
        repeat (3) @(negedge clk);
        check("R1 bit", int'(bit_o), 0);
        check("R1 valid", int'(bit_vld_o), 0);
        rst = 1'b0;

        // R8: default coefficient zero behaves as a zero-threshold slicer
        slice(1, 1, "R8 +1 after 0");
        slice(1, 1, "R8 +1 after 1");
        slice(0, 0, "R8 tie at 0 after 1");
        slice(-1, 0, "R8 -1 after 0");

        // Table walk, coefficient 256, from decision 0
        do_reset();
        load_coef(256);
        for (int i = 0; i < NTBL; i++) begin
            smp_i     = TBL[i][W-1:0];
            smp_vld_i = TBL[i][W+1];
            @(negedge clk);
            check($sformatf("R3/R4/R5/R6 table row %0d bit", i), int'(bit_o), int'(TBL[i][W]));
            check($sformatf("R2 table row %0d valid", i), int'(bit_vld_o), int'(TBL[i][W+1]));
        end
        smp_vld_i = 1'b0;
        @(negedge clk);
        check("R2 valid low after stream", int'(bit_vld_o), 0);

        // R7: write during a valid sample is ignored (coefficient stays 256)
        do_reset();
        load_coef(256);
        coef_wr_i = 1'b1; coef_i = '0;
        slice(300, 1, "R7 sample with blocked write");
        coef_wr_i = 1'b0;
        slice(100, 0, "R7 coefficient unchanged");
        // idle write takes effect for the next sample
        load_coef(0);
        slice(1, 1, "R7 idle write applied (+1 vs 0)");
        slice(100, 1, "R7 idle write applied (100 vs 0)");

        // R9: coefficient at the range ends
        do_reset();
        load_coef(-2048);
        slice(2047, 0, "R9 most negative, prev 0, thr +2048");
        slice(-2048, 0, "R9 most negative, prev 0 again");
        do_reset();
        load_coef(2047);
        slice(-2047, 0, "R9 most positive, tie at -2047");
        slice(-2046, 1, "R9 most positive, above -2047");
        slice(2047, 0, "R9 most positive, tie at +2047");

        // R10: channel runs
        run_channel(205, 300, de, ze);
        check("R10 errors, a=0.4", de, 0);
        run_channel(640, 400, de, ze);
        check("R10 errors, a=1.25", de, 0);
        check("R10 zero slicer errs, a=1.25", int'(ze > 0), 1);

        summary();
    end

endmodule